// File: doc/BRIEF.md
# Window Base Setup Frame Transmit Controller

This block lives on the sending side of a serial link between processors. The link carries several independent pipes. Each pipe owns a remote memory window on the far processor. Software moves a window by writing the pipe's base register. The block keeps the upper 28 address bits and a 4-bit coded window size for each pipe. It reports the most recent write on a shared status view, which holds the address bits, the pipe number and a valid flag. It then hands a setup frame for that pipe to the link shifter, but only once the pipe is idle and the link says it is ready.

The shifter answers each request with a good or a bad acknowledgement. On a bad acknowledgement, or on silence for a programmable number of cycles, the block offers the same frame again and the valid flag stays up. On a good acknowledgement it marks a per-pipe sent event, which software clears by writing 1. It raises an interrupt for events whose enable bit is set. It also tells the data framer to send the next two data frames uncompressed, so that the far side can resynchronise its offset prediction.

Top module: `winbase_tx`

## Requirements
- R1: One cycle after a write strobe, `cp_addr` holds the written 28 address bits and `st_pipe` holds the written pipe number.
- R2: `st_bav` is 1 from the cycle after a write until the good acknowledgement of the last outstanding setup frame. It is 0 in the cycle after that acknowledgement.
- R3: `frm_req` rises only after a cycle in which the chosen pipe's `pipe_idle` bit and `link_ready` were both 1. While `frm_req` is high, `frm_payload` holds the address bits in [31:4] and the coded size in [3:0], and `frm_pipe` names the pipe.
- R4: When several pipes are pending and idle, the lowest-numbered pipe is sent first.
- R5: `frm_nak` during a request drops `frm_req` for one cycle and then offers the same payload again, with `st_bav` still 1.
- R6: If a request gets no answer, `frm_req` stays high for `tmo_limit`+1 cycles, drops for one cycle, and then rises again with the same frame.
- R7: One cycle after a good acknowledgement (`frm_ack` while `frm_req` is high), `evt_sent[frm_pipe]` is 1.
- R8: `irq` is 1 exactly when some pipe has both its `evt_sent` bit and its `irq_en` bit set.
- R9: Writing 1 to `evt_clr[p]` clears `evt_sent[p]` one cycle later. A clear in the same cycle as that pipe's acknowledgement leaves the bit set.
- R10: After a good acknowledgement, `opt_block` is 1 until two `data_done` pulses have been seen, and 0 after that.
- R11: After reset, `frm_req`, `st_bav`, `evt_sent`, `irq` and `opt_block` are all 0.
- R12: A write to a pipe whose frame is in flight leaves that frame's payload unchanged. After the acknowledgement, a new frame is sent with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Base register write strobe |
| wr_pipe | input | 2 | Pipe addressed by the write |
| wr_base | input | 28 | Upper 28 address bits written |
| wr_bsize | input | 4 | Coded window size written |
| pipe_idle | input | 4 | Per-pipe idle indication |
| link_ready | input | 1 | Link can accept a frame |
| tmo_limit | input | 8 | Answer timeout in cycles, minus one |
| frm_req | output | 1 | Setup frame offered to the shifter |
| frm_pipe | output | 2 | Pipe of the offered frame |
| frm_payload | output | 32 | Address bits and coded size |
| frm_ack | input | 1 | Good acknowledgement |
| frm_nak | input | 1 | Bad acknowledgement |
| data_done | input | 1 | One data frame finished |
| evt_clr | input | 4 | Write-1 clear of sent events |
| irq_en | input | 4 | Per-pipe interrupt enable |
| cp_addr | output | 28 | Shared copy of the last written address bits |
| st_pipe | output | 2 | Pipe of the last write |
| st_bav | output | 1 | Base address valid |
| evt_sent | output | 4 | Per-pipe setup frame sent events |
| irq | output | 1 | Interrupt request |
| opt_block | output | 1 | Forces uncompressed data framing |

## Verification
The bench builds the block with its defaults: four pipes, an 8-bit timeout counter and a suppression window of two data frames. With four pipes, three writes can be queued behind a closed link, which checks the lowest-first order over a pending set that has a gap in it. A `tmo_limit` of 3 keeps a full timeout and resend within a handful of cycles, so the exact width of the request window can be counted. A window of two frames lets the bench see the one step where the count falls but the block stays on, as well as the step that releases it.

// File: rtl/winbase_pkg.sv
package winbase_pkg;
  localparam int ADDR_W = 32;
  localparam int BS_W   = 4;
  localparam int HI_W   = ADDR_W - BS_W;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_REQ  = 2'd1,
    LS_HOLD = 2'd2
  } link_state_e;

  // setup frame body: address bits above the size nibble
  function automatic logic [ADDR_W-1:0] pack_frame(
      input logic [HI_W-1:0] hi, input logic [BS_W-1:0] bs);
    return {hi, bs};
  endfunction

  function automatic logic timed_out(
      input logic [7:0] tmr, input logic [7:0] lim);
    return tmr == lim;
  endfunction
endpackage

// File: rtl/winbase_regs.sv
module winbase_regs
  import winbase_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PW-1:0]            wr_pipe,
  input  logic [HI_W-1:0]          wr_base,
  input  logic [BS_W-1:0]          wr_bsize,
  input  logic                     launch,
  input  logic [PW-1:0]            launch_pipe,
  output logic [NP-1:0]            pend,
  output logic [NP-1:0][HI_W-1:0]  shd_hi,
  output logic [NP-1:0][BS_W-1:0]  shd_bs,
  output logic [HI_W-1:0]          cp_addr,
  output logic [PW-1:0]            st_pipe
);
  for (genvar g = 0; g < NP; g++) begin : g_pipe
    logic            hit;
    logic            take;
    logic            pend_q;
    logic [HI_W-1:0] hi_q;
    logic [BS_W-1:0] bs_q;

    assign hit  = wr_en && (wr_pipe == PW'(g));
    assign take = launch && (launch_pipe == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        hi_q   <= '0;
        bs_q   <= '0;
      end else begin
        // a write in the launch cycle keeps the pipe pending
        pend_q <= hit | (pend_q & ~take);
        if (hit) begin
          hi_q <= wr_base;
          bs_q <= wr_bsize;
        end
      end
    end

    assign pend[g]   = pend_q;
    assign shd_hi[g] = hi_q;
    assign shd_bs[g] = bs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_addr <= '0;
      st_pipe <= '0;
    end else if (wr_en) begin
      cp_addr <= wr_base;
      st_pipe <= wr_pipe;
    end
  end
endmodule

// File: rtl/winbase_arb.sv
module winbase_arb #(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input  logic [NP-1:0] pend,
  input  logic [NP-1:0] pipe_idle,
  input  logic          link_ready,
  output logic          cand_vld,
  output logic [PW-1:0] pick
);
  logic [NP-1:0] cand;

  function automatic logic [PW-1:0] lowest_set(input logic [NP-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  assign cand     = pend & pipe_idle & {NP{link_ready}};
  assign cand_vld = |cand;
  assign pick     = lowest_set(cand);
endmodule

// File: rtl/winbase_link.sv
module winbase_link
  import winbase_pkg::*;
#(
  parameter int NP    = 4,
  parameter int PW    = 2,
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_vld,
  input  logic [PW-1:0]     pick,
  input  logic [ADDR_W-1:0] sel_payload,
  input  logic [NP-1:0]     pipe_idle,
  input  logic              link_ready,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              frm_ack,
  input  logic              frm_nak,
  output logic              frm_req,
  output logic [PW-1:0]     frm_pipe,
  output logic [ADDR_W-1:0] frm_payload,
  output logic              launch,
  output logic              ack_done,
  output logic              retry_ev,
  output logic              busy
);
  link_state_e      state_q;
  logic [TMO_W-1:0] tmr_q;
  logic             expired;
  logic             relaunch;

  assign frm_req  = (state_q == LS_REQ);
  assign busy     = (state_q != LS_IDLE);
  assign launch   = (state_q == LS_IDLE) && cand_vld;
  assign ack_done = frm_req && frm_ack;
  assign expired  = timed_out(8'(tmr_q), 8'(tmo_limit));
  assign retry_ev = frm_req && !frm_ack && (frm_nak || expired);
  assign relaunch = (state_q == LS_HOLD) && pipe_idle[frm_pipe] && link_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LS_IDLE;
      tmr_q       <= '0;
      frm_pipe    <= '0;
      frm_payload <= '0;
    end else begin
      case (state_q)
        LS_IDLE: if (launch) begin
          state_q     <= LS_REQ;
          tmr_q       <= '0;
          frm_pipe    <= pick;
          frm_payload <= sel_payload;
        end
        LS_REQ: begin
          if (ack_done)      state_q <= LS_IDLE;
          else if (retry_ev) state_q <= LS_HOLD;
          tmr_q <= tmr_q + 1'b1;
        end
        LS_HOLD: if (relaunch) begin
          state_q <= LS_REQ;
          tmr_q   <= '0;
        end
        default: state_q <= LS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/winbase_evt.sv
module winbase_evt #(
  parameter int NP   = 4,
  parameter int PW   = 2,
  parameter int SUPP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_done,
  input  logic [PW-1:0] act_pipe,
  input  logic [NP-1:0] evt_clr,
  input  logic [NP-1:0] irq_en,
  input  logic          data_done,
  output logic [NP-1:0] evt_sent,
  output logic          irq,
  output logic          opt_block
);
  localparam int CW = $clog2(SUPP + 1);

  logic [CW-1:0] supp_q;

  for (genvar g = 0; g < NP; g++) begin : g_evt
    logic set_g;
    logic evt_q;
    assign set_g = ack_done && (act_pipe == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= set_g | (evt_q & ~evt_clr[g]);
    end
    assign evt_sent[g] = evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        supp_q <= '0;
    else if (ack_done)                 supp_q <= CW'(SUPP);
    else if (data_done && supp_q != 0) supp_q <= supp_q - 1'b1;
  end

  assign opt_block = (supp_q != 0);
  assign irq       = |(evt_sent & irq_en);
endmodule

// File: rtl/winbase_tx.sv
module winbase_tx
  import winbase_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int TMO_W     = 8,
  parameter int SUPP      = 2,
  localparam int PW       = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PW-1:0]        wr_pipe,
  input  logic [HI_W-1:0]      wr_base,
  input  logic [BS_W-1:0]      wr_bsize,
  input  logic [NUM_PIPES-1:0] pipe_idle,
  input  logic                 link_ready,
  input  logic [TMO_W-1:0]     tmo_limit,
  output logic                 frm_req,
  output logic [PW-1:0]        frm_pipe,
  output logic [ADDR_W-1:0]    frm_payload,
  input  logic                 frm_ack,
  input  logic                 frm_nak,
  input  logic                 data_done,
  input  logic [NUM_PIPES-1:0] evt_clr,
  input  logic [NUM_PIPES-1:0] irq_en,
  output logic [HI_W-1:0]      cp_addr,
  output logic [PW-1:0]        st_pipe,
  output logic                 st_bav,
  output logic [NUM_PIPES-1:0] evt_sent,
  output logic                 irq,
  output logic                 opt_block
);
  logic [NUM_PIPES-1:0]            pend;
  logic [NUM_PIPES-1:0][HI_W-1:0]  shd_hi;
  logic [NUM_PIPES-1:0][BS_W-1:0]  shd_bs;
  logic                            cand_vld;
  logic [PW-1:0]                   pick;
  logic [ADDR_W-1:0]               sel_payload;
  logic                            launch;
  logic                            ack_done;
  logic                            retry_ev;
  logic                            busy;

  winbase_regs #(.NP(NUM_PIPES), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pipe(wr_pipe),
    .wr_base(wr_base), .wr_bsize(wr_bsize), .launch(launch),
    .launch_pipe(pick), .pend(pend), .shd_hi(shd_hi), .shd_bs(shd_bs),
    .cp_addr(cp_addr), .st_pipe(st_pipe)
  );

  winbase_arb #(.NP(NUM_PIPES), .PW(PW)) u_arb (
    .pend(pend), .pipe_idle(pipe_idle), .link_ready(link_ready),
    .cand_vld(cand_vld), .pick(pick)
  );

  assign sel_payload = pack_frame(shd_hi[pick], shd_bs[pick]);

  winbase_link #(.NP(NUM_PIPES), .PW(PW), .TMO_W(TMO_W)) u_link (
    .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .pick(pick),
    .sel_payload(sel_payload), .pipe_idle(pipe_idle),
    .link_ready(link_ready), .tmo_limit(tmo_limit), .frm_ack(frm_ack),
    .frm_nak(frm_nak), .frm_req(frm_req), .frm_pipe(frm_pipe),
    .frm_payload(frm_payload), .launch(launch), .ack_done(ack_done),
    .retry_ev(retry_ev), .busy(busy)
  );

  winbase_evt #(.NP(NUM_PIPES), .PW(PW), .SUPP(SUPP)) u_evt (
    .clk(clk), .rst_n(rst_n), .ack_done(ack_done), .act_pipe(frm_pipe),
    .evt_clr(evt_clr), .irq_en(irq_en), .data_done(data_done),
    .evt_sent(evt_sent), .irq(irq), .opt_block(opt_block)
  );

  assign st_bav = (|pend) | busy;
endmodule

// File: rtl/winbase_tx_chk.sv
module winbase_tx_chk #(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [PW-1:0] wr_pipe,
  input logic [NP-1:0] pipe_idle,
  input logic          link_ready,
  input logic          frm_req,
  input logic [PW-1:0] frm_pipe,
  input logic [31:0]   frm_payload,
  input logic          frm_ack,
  input logic          frm_nak,
  input logic [PW-1:0] st_pipe,
  input logic          st_bav,
  input logic [NP-1:0] evt_sent,
  input logic          opt_block,
  input logic          retry_ev
);
  logic [NP-1:0] idle_q;
  logic          ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      idle_q  <= pipe_idle;
      ready_q <= link_ready;
    end
  end

  AST_PIPE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> st_pipe == $past(wr_pipe));                           // R1
  AST_BAV_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> st_bav);                                              // R2
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_req) |-> ready_q && idle_q[frm_pipe]);                // R3
  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && $past(frm_req) |-> $stable(frm_payload) && $stable(frm_pipe)); // R3
  AST_NAK_KEEPS_BAV: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && frm_nak && !frm_ack |=> st_bav && !frm_req);         // R5
  AST_RETRY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ev |=> !frm_req);                                         // R6
  AST_EVT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && frm_ack |=> evt_sent[$past(frm_pipe)]);              // R7
  AST_OPT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    frm_req && frm_ack |=> opt_block);                              // R10
endmodule

bind winbase_tx winbase_tx_chk #(.NP(NUM_PIPES), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pipe(wr_pipe),
  .pipe_idle(pipe_idle), .link_ready(link_ready), .frm_req(frm_req),
  .frm_pipe(frm_pipe), .frm_payload(frm_payload), .frm_ack(frm_ack),
  .frm_nak(frm_nak), .st_pipe(st_pipe), .st_bav(st_bav),
  .evt_sent(evt_sent), .opt_block(opt_block), .retry_ev(retry_ev)
);

// File: tb/test_winbase_tx.sv
module test_winbase_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_pipe = '0;
  logic [27:0] wr_base = '0;
  logic [3:0]  wr_bsize = '0;
  logic [3:0]  pipe_idle = 4'hF;
  logic        link_ready = 1'b1;
  logic [7:0]  tmo_limit = 8'd40;
  logic        frm_req;
  logic [1:0]  frm_pipe;
  logic [31:0] frm_payload;
  logic        frm_ack = 1'b0;
  logic        frm_nak = 1'b0;
  logic        data_done = 1'b0;
  logic [3:0]  evt_clr = '0;
  logic [3:0]  irq_en = '0;
  logic [27:0] cp_addr;
  logic [1:0]  st_pipe;
  logic        st_bav;
  logic [3:0]  evt_sent;
  logic        irq;
  logic        opt_block;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  winbase_tx i_winbase_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pipe(wr_pipe),
    .wr_base(wr_base), .wr_bsize(wr_bsize), .pipe_idle(pipe_idle),
    .link_ready(link_ready), .tmo_limit(tmo_limit), .frm_req(frm_req),
    .frm_pipe(frm_pipe), .frm_payload(frm_payload), .frm_ack(frm_ack),
    .frm_nak(frm_nak), .data_done(data_done), .evt_clr(evt_clr),
    .irq_en(irq_en), .cp_addr(cp_addr), .st_pipe(st_pipe),
    .st_bav(st_bav), .evt_sent(evt_sent), .irq(irq), .opt_block(opt_block)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_base(input logic [1:0] p, input logic [31:0] addr, input logic [3:0] bs);
    wr_en = 1'b1; wr_pipe = p; wr_base = addr[31:4]; wr_bsize = bs;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ack_now();
    frm_ack = 1'b1;
    step();
    frm_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 frm_req", 32'(frm_req), 0);
    check("R11 st_bav", 32'(st_bav), 0);
    check("R11 evt_sent", 32'(evt_sent), 0);
    check("R11 irq", 32'(irq), 0);
    check("R11 opt_block", 32'(opt_block), 0);
  endtask

  task automatic t_basic();
    write_base(2'd2, 32'hABCDE120, 4'd5);
    check("R1 cp_addr", 32'(cp_addr), 32'h0ABCDE12);
    check("R1 st_pipe", 32'(st_pipe), 2);
    check("R2 bav set", 32'(st_bav), 1);
    check("R3 no req yet", 32'(frm_req), 0);
    step();
    check("R3 req", 32'(frm_req), 1);
    check("R3 payload", frm_payload, 32'hABCDE125);
    check("R3 pipe", 32'(frm_pipe), 2);
    ack_now();
    check("R2 bav clear", 32'(st_bav), 0);
    check("R7 evt", 32'(evt_sent), 32'h4);
    check("R8 irq masked", 32'(irq), 0);
    check("R10 opt on", 32'(opt_block), 1);
    irq_en = 4'h4; #1;
    check("R8 irq enabled", 32'(irq), 1);
    irq_en = 4'h3; #1;
    check("R8 irq other pipes", 32'(irq), 0);
    data_done = 1'b1; step();
    check("R10 opt after 1", 32'(opt_block), 1);
    step(); data_done = 1'b0;
    check("R10 opt after 2", 32'(opt_block), 0);
    evt_clr = 4'h4; step(); evt_clr = '0;
    check("R9 clear", 32'(evt_sent), 0);
  endtask

  task automatic t_gate();
    link_ready = 1'b0;
    write_base(2'd1, 32'h12345670, 4'd3);
    repeat (3) step();
    check("R3 link not ready", 32'(frm_req), 0);
    check("R2 bav held", 32'(st_bav), 1);
    link_ready = 1'b1; pipe_idle = 4'hD;
    repeat (3) step();
    check("R3 pipe busy", 32'(frm_req), 0);
    pipe_idle = 4'hF; step();
    check("R3 req after idle", 32'(frm_req), 1);
    check("R3 gate payload", frm_payload, 32'h12345673);
    ack_now();
    step();
  endtask

  task automatic t_prio();
    link_ready = 1'b0;
    write_base(2'd3, 32'h33333330, 4'd3);
    write_base(2'd1, 32'h11111110, 4'd1);
    write_base(2'd0, 32'h00000A00, 4'd0);
    check("R1 last pipe", 32'(st_pipe), 0);
    link_ready = 1'b1; step();
    check("R4 first pipe 0", 32'(frm_pipe), 0);
    ack_now();
    check("R2 bav with pending", 32'(st_bav), 1);
    step();
    check("R4 second pipe 1", 32'(frm_pipe), 1);
    check("R4 second payload", frm_payload, 32'h11111111);
    ack_now(); step();
    check("R4 third pipe 3", 32'(frm_pipe), 3);
    ack_now();
    check("R2 bav after all", 32'(st_bav), 0);
    evt_clr = 4'hF; step(); evt_clr = '0;
  endtask

  task automatic t_nak();
    write_base(2'd0, 32'hFEDCBA90, 4'd9);
    step();
    check("R5 req", 32'(frm_req), 1);
    frm_nak = 1'b1; step(); frm_nak = 1'b0;
    check("R5 drop", 32'(frm_req), 0);
    check("R5 bav kept", 32'(st_bav), 1);
    check("R5 no event", 32'(evt_sent), 0);
    step();
    check("R5 resend", 32'(frm_req), 1);
    check("R5 same payload", frm_payload, 32'hFEDCBA99);
    ack_now();
    step();
  endtask

  task automatic t_tmo();
    logic [5:0] seen;
    tmo_limit = 8'd3;
    write_base(2'd2, 32'h0F0F0F00, 4'd2);
    step();
    for (int i = 5; i >= 0; i--) begin
      seen[i] = frm_req;
      step();
    end
    check("R6 window", 32'(seen), 32'b111101);
    check("R6 bav kept", 32'(st_bav), 1);
    check("R6 payload", frm_payload, 32'h0F0F0F02);
    ack_now();
    tmo_limit = 8'd40;
    evt_clr = 4'hF; step(); evt_clr = '0;
  endtask

  task automatic t_inflight();
    write_base(2'd1, 32'hAAAAAAA0, 4'd1);
    step();
    check("R12 first", frm_payload, 32'hAAAAAAA1);
    write_base(2'd1, 32'hBBBBBBB0, 4'd7);
    check("R12 held", frm_payload, 32'hAAAAAAA1);
    check("R1 cp new", 32'(cp_addr), 32'h0BBBBBBB);
    frm_ack = 1'b1; evt_clr = 4'h2; step(); frm_ack = 1'b0; evt_clr = '0;
    check("R9 set wins", 32'(evt_sent), 32'h2);
    check("R12 bav still", 32'(st_bav), 1);
    step();
    check("R12 resend", 32'(frm_req), 1);
    check("R12 new payload", frm_payload, 32'hBBBBBBB7);
    ack_now();
    check("R2 bav done", 32'(st_bav), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_gate();
    t_prio();
    t_nak();
    t_tmo();
    t_inflight();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule